// File: doc/BRIEF.md
# Command-Block DMA Engine

This block is a bus master that carries out jobs described by command blocks held in system memory. The host writes the byte address of a command block into the start register. The engine then uses its single memory port to read the six-word block and the input scatter-gather list. It carries out the job and writes a status word back into the block. Last, it raises a level interrupt that stays set until the host clears it.

A job either loads a 64-bit key into the engine or pushes data through a transform stage. For a transform job the engine first reads the whole output scatter-gather list into internal buffers. It then loops over the data: read one 64-bit input block, transform it, and write it to the output list. The input and output lists may cut the stream into segments at different points. The transform is a stand-in for a real cipher and uses the stored key. It has separate encrypt and decrypt forms, chosen per job.

Top module: `dma_cb_engine`

## Requirements
- R1: A write with `reg_sel`=0 while idle starts a job at the byte address in `reg_wdata`. The command block is six 32-bit words at byte offsets +0 opcode, +4 status, +8 input list address, +12 input entry count, +16 output list address, +20 output entry count. The status word is the only word of the block that the engine writes.
- R2: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until the cycle in which `mem_ack` is high. Each acknowledge moves one 32-bit word.
- R3: Opcode 1 loads the key, 2 encrypts and 3 decrypts. Any other opcode finishes with status 2 and moves no data.
- R4: A key load needs an input list whose total length is exactly 8 bytes. The key then becomes {word at +4, word at +0} of that data. In any other case the status is 1 and the key keeps its old value.
- R5: A 64-bit block is {word at +4, word at +0}. Encrypt writes ((x XOR key) + key) mod 2^64. Decrypt writes ((x - key) mod 2^64) XOR key.
- R6: Each list entry is two words, address then byte length. Segments are used in list order and zero-length segments are skipped. Input and output may be split at different places.
- R7: A transform job finishes with status 1 and writes no output if its input and output totals differ or any segment length is not a multiple of 8. Two empty lists finish with status 0.
- R8: A list with more than 16 entries (`MAX_ENT`) finishes with status 3 and moves no data. The output count is ignored for a key load.
- R9: Status 0 means success. The status is written to block base +4, and `irq` rises in the cycle after that write is acknowledged.
- R10: `irq` stays high until a write with `reg_sel`=1 and `reg_wdata[0]`=1. A clear write with bit 0 at 0 has no effect.
- R11: A start write while a job runs is ignored and sets `overrun`, which stays high until reset.
- R12: After reset `irq`, `overrun` and `mem_req` are low and the key is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 = start register, 1 = interrupt clear |
| reg_wdata | input | 32 | Host write data |
| irq | output | 1 | Job-complete interrupt |
| overrun | output | 1 | Sticky flag for a start write while busy |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Transform jobs are run with several kinds of segmentation: matching single segments, input and output split at different points, zero-length segments on either side, and misaligned lengths. These show whether the stream is walked in order across segment edges and whether a length error blocks every output write. Encrypt and decrypt run under both the reset key and a loaded key, so a swapped direction or a missed key load shows up. Key loads with wrong totals, bad opcodes and oversized counts are each followed by a job that exposes the key and the untouched output buffers.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CB,
      S_DECODE,
      S_INLIST,
      S_OUTLIST,
      S_CHECK,
      S_IN_LO,
      S_IN_HI,
      S_OUT_LO,
      S_OUT_HI,
      S_STATUS
   } eng_state_e;

   localparam logic [31:0] OP_KEY = 32'd1;
   localparam logic [31:0] OP_ENC = 32'd2;
   localparam logic [31:0] OP_DEC = 32'd3;

   localparam logic [1:0] STS_OK  = 2'd0;
   localparam logic [1:0] STS_LEN = 2'd1;
   localparam logic [1:0] STS_OP  = 2'd2;
   localparam logic [1:0] STS_CNT = 2'd3;

   localparam int CB_WORDS = 6;

endpackage

// File: rtl/dma_sg_buf.sv
module dma_sg_buf #(
   parameter int ENTRIES = 16,
   parameter int AW      = 32,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_len,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_addr,
   output logic [AW-1:0] rd_len
);

   logic [AW-1:0] addr_arr [ENTRIES];
   logic [AW-1:0] len_arr  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [AW-1:0] a_q;
      logic [AW-1:0] l_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            l_q <= '0;
         end else if (wr_en && wr_idx == IW'(e)) begin
            if (wr_len) l_q <= wr_data;
            else        a_q <= wr_data;
         end
      end

      assign addr_arr[e] = a_q;
      assign len_arr[e]  = l_q;
   end

   assign rd_addr = addr_arr[rd_idx];
   assign rd_len  = len_arr[rd_idx];

endmodule

// File: rtl/dma_xform.sv
module dma_xform #(
   parameter int BW  = 64,
   parameter bit MIX = 1'b1
) (
   input  logic [BW-1:0] din,
   input  logic [BW-1:0] key,
   input  logic          dec,
   output logic [BW-1:0] dout
);

   if (MIX) begin : g_mix
      assign dout = dec ? ((din - key) ^ key) : ((din ^ key) + key);
   end else begin : g_xor
      logic unused_dec;
      assign unused_dec = dec;
      assign dout = din ^ key;
   end

endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
   import dma_cb_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int MAX_ENT = 16,
   parameter bit MIX     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic          irq,
   output logic          overrun,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);

   localparam int CNT_W  = $clog2(MAX_ENT + 1);
   localparam int WIDX_W = CNT_W + 1;
   localparam int IW     = $clog2(MAX_ENT);
   localparam int BW     = 2 * DW;

   if (DW != 32) begin : g_bad_dw
      $error("dma_cb_engine: DW must be 32");
   end
   if (AW != DW) begin : g_bad_aw
      $error("dma_cb_engine: AW must equal DW");
   end
   if (MAX_ENT < 2) begin : g_bad_ent
      $error("dma_cb_engine: MAX_ENT must be at least 2");
   end

   eng_state_e        state;
   logic [AW-1:0]     cb_base;
   logic [DW-1:0]     op_q;
   logic [AW-1:0]     in_base, out_base;
   logic [DW-1:0]     in_cnt_raw, out_cnt_raw;
   logic [CNT_W-1:0]  in_n, out_n;
   logic [WIDX_W-1:0] widx;
   logic [DW-1:0]     in_tot, out_tot, remain;
   logic              misal;
   logic [1:0]        sts_q;
   logic [BW-1:0]     key_q, blk_q, xo;
   logic [DW-1:0]     lo_q;
   logic [CNT_W-1:0]  in_idx, out_idx;
   logic [AW-1:0]     in_off, out_off;
   logic              irq_q, ovr_q;

   logic [AW-1:0] in_seg_addr, in_seg_len, out_seg_addr, out_seg_len;
   logic          acc, irq_set, clr_hit, start_hit;
   logic          valid_op, is_key, is_dec;
   logic          in_list_done, out_list_done, in_skip, out_skip;
   logic          len_bad;
   logic          in_wr_en, out_wr_en;
   logic [AW-1:0] widx_off;

   assign valid_op  = (op_q == OP_KEY) || (op_q == OP_ENC) || (op_q == OP_DEC);
   assign is_key    = (op_q == OP_KEY);
   assign is_dec    = (op_q == OP_DEC);
   assign start_hit = reg_wr && !reg_sel;
   assign clr_hit   = reg_wr && reg_sel && reg_wdata[0];
   assign widx_off  = AW'({widx, 2'b00});

   assign in_list_done  = (widx == {in_n, 1'b0});
   assign out_list_done = (widx == {out_n, 1'b0});
   assign in_skip       = (state == S_IN_LO)  && (in_off == in_seg_len);
   assign out_skip      = (state == S_OUT_LO) && (out_off == out_seg_len);
   assign len_bad       = misal || (is_key ? (in_tot != DW'(8)) : (in_tot != out_tot));

   dma_sg_buf #(.ENTRIES(MAX_ENT), .AW(AW)) i_in_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_wr_en),
      .wr_len  (widx[0]),
      .wr_idx  (IW'(widx[WIDX_W-1:1])),
      .wr_data (mem_rdata),
      .rd_idx  (IW'(in_idx)),
      .rd_addr (in_seg_addr),
      .rd_len  (in_seg_len)
   );

   dma_sg_buf #(.ENTRIES(MAX_ENT), .AW(AW)) i_out_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (out_wr_en),
      .wr_len  (widx[0]),
      .wr_idx  (IW'(widx[WIDX_W-1:1])),
      .wr_data (mem_rdata),
      .rd_idx  (IW'(out_idx)),
      .rd_addr (out_seg_addr),
      .rd_len  (out_seg_len)
   );

   dma_xform #(.BW(BW), .MIX(MIX)) i_xform (
      .din  (blk_q),
      .key  (key_q),
      .dec  (is_dec),
      .dout (xo)
   );

   // Memory port request generation
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         S_CB: begin
            mem_req  = 1'b1;
            mem_addr = cb_base + widx_off;
         end
         S_INLIST: begin
            mem_req  = !in_list_done;
            mem_addr = in_base + widx_off;
         end
         S_OUTLIST: begin
            mem_req  = !out_list_done;
            mem_addr = out_base + widx_off;
         end
         S_IN_LO: begin
            mem_req  = !in_skip;
            mem_addr = in_seg_addr + in_off;
         end
         S_IN_HI: begin
            mem_req  = 1'b1;
            mem_addr = in_seg_addr + in_off + AW'(4);
         end
         S_OUT_LO: begin
            mem_req   = !out_skip;
            mem_we    = 1'b1;
            mem_addr  = out_seg_addr + out_off;
            mem_wdata = xo[DW-1:0];
         end
         S_OUT_HI: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = out_seg_addr + out_off + AW'(4);
            mem_wdata = xo[BW-1:DW];
         end
         S_STATUS: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cb_base + AW'(4);
            mem_wdata = DW'(sts_q);
         end
         default: ;
      endcase
   end

   assign acc       = mem_req && mem_ack;
   assign irq_set   = (state == S_STATUS) && acc;
   assign in_wr_en  = (state == S_INLIST) && acc;
   assign out_wr_en = (state == S_OUTLIST) && acc;

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cb_base     <= '0;
         op_q        <= '0;
         in_base     <= '0;
         out_base    <= '0;
         in_cnt_raw  <= '0;
         out_cnt_raw <= '0;
         in_n        <= '0;
         out_n       <= '0;
         widx        <= '0;
         in_tot      <= '0;
         out_tot     <= '0;
         remain      <= '0;
         misal       <= 1'b0;
         sts_q       <= STS_OK;
         key_q       <= '0;
         blk_q       <= '0;
         lo_q        <= '0;
         in_idx      <= '0;
         out_idx     <= '0;
         in_off      <= '0;
         out_off     <= '0;
         irq_q       <= 1'b0;
         ovr_q       <= 1'b0;
      end else begin
         if (irq_set)      irq_q <= 1'b1;
         else if (clr_hit) irq_q <= 1'b0;

         if (start_hit && state != S_IDLE) ovr_q <= 1'b1;

         unique case (state)
            S_IDLE: begin
               if (start_hit) begin
                  cb_base <= reg_wdata;
                  widx    <= '0;
                  state   <= S_CB;
               end
            end
            S_CB: begin
               if (acc) begin
                  case (widx)
                     WIDX_W'(0): op_q        <= mem_rdata;
                     WIDX_W'(2): in_base     <= mem_rdata;
                     WIDX_W'(3): in_cnt_raw  <= mem_rdata;
                     WIDX_W'(4): out_base    <= mem_rdata;
                     WIDX_W'(5): out_cnt_raw <= mem_rdata;
                     default: ;
                  endcase
                  if (widx == WIDX_W'(CB_WORDS - 1)) state <= S_DECODE;
                  else                               widx  <= widx + 1'b1;
               end
            end
            S_DECODE: begin
               widx    <= '0;
               in_tot  <= '0;
               out_tot <= '0;
               misal   <= 1'b0;
               if (!valid_op) begin
                  sts_q <= STS_OP;
                  state <= S_STATUS;
               end else if (in_cnt_raw > DW'(MAX_ENT) ||
                            (!is_key && out_cnt_raw > DW'(MAX_ENT))) begin
                  sts_q <= STS_CNT;
                  state <= S_STATUS;
               end else begin
                  in_n  <= in_cnt_raw[CNT_W-1:0];
                  out_n <= is_key ? '0 : out_cnt_raw[CNT_W-1:0];
                  state <= S_INLIST;
               end
            end
            S_INLIST: begin
               if (in_list_done) begin
                  widx  <= '0;
                  state <= is_key ? S_CHECK : S_OUTLIST;
               end else if (acc) begin
                  if (widx[0]) begin
                     in_tot <= in_tot + mem_rdata;
                     misal  <= misal | (|mem_rdata[2:0]);
                  end
                  widx <= widx + 1'b1;
               end
            end
            S_OUTLIST: begin
               if (out_list_done) begin
                  widx  <= '0;
                  state <= S_CHECK;
               end else if (acc) begin
                  if (widx[0]) begin
                     out_tot <= out_tot + mem_rdata;
                     misal   <= misal | (|mem_rdata[2:0]);
                  end
                  widx <= widx + 1'b1;
               end
            end
            S_CHECK: begin
               in_idx  <= '0;
               out_idx <= '0;
               in_off  <= '0;
               out_off <= '0;
               remain  <= in_tot;
               if (len_bad) begin
                  sts_q <= STS_LEN;
                  state <= S_STATUS;
               end else begin
                  sts_q <= STS_OK;
                  state <= (in_tot == '0) ? S_STATUS : S_IN_LO;
               end
            end
            S_IN_LO: begin
               if (in_skip) begin
                  in_idx <= in_idx + 1'b1;
                  in_off <= '0;
               end else if (acc) begin
                  lo_q  <= mem_rdata;
                  state <= S_IN_HI;
               end
            end
            S_IN_HI: begin
               if (acc) begin
                  blk_q  <= {mem_rdata, lo_q};
                  in_off <= in_off + AW'(8);
                  remain <= remain - DW'(8);
                  if (is_key) begin
                     key_q <= {mem_rdata, lo_q};
                     state <= S_STATUS;
                  end else begin
                     state <= S_OUT_LO;
                  end
               end
            end
            S_OUT_LO: begin
               if (out_skip) begin
                  out_idx <= out_idx + 1'b1;
                  out_off <= '0;
               end else if (acc) begin
                  state <= S_OUT_HI;
               end
            end
            S_OUT_HI: begin
               if (acc) begin
                  out_off <= out_off + AW'(8);
                  state   <= (remain == '0) ? S_STATUS : S_IN_LO;
               end
            end
            S_STATUS: begin
               if (acc) state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign irq     = irq_q;
   assign overrun = ovr_q;

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R9
   irq_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mem_req && mem_ack && mem_we && mem_addr == cb_base + AW'(4)));

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_hit) |=> irq);

   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && state != S_IDLE) |=> (overrun && $stable(cb_base)));

   // R7
   no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && state != S_STATUS) |-> (sts_q == STS_OK));

   // R8
   list_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_INLIST || state == S_OUTLIST) && mem_req) |-> (widx < WIDX_W'(2 * MAX_ENT)));

endmodule

// File: tb/test_dma_cb_engine.sv
module test_dma_cb_engine;

   localparam int CB     = 32'h100;
   localparam int CB_ALT = 32'h900;
   localparam int CB2    = 32'hA00;
   localparam int IN_L   = 32'h200;
   localparam int OUT_L  = 32'h280;
   localparam int IN0    = 32'h400;
   localparam int IN1    = 32'h500;
   localparam int OUT0   = 32'h600;
   localparam int OUT1   = 32'h700;
   localparam int NVEC   = 12;

   // {opcode[41:34], in0[33:26], in1[25:18], out0[17:10], out1[9:2], status[1:0]}
   localparam logic [41:0] VEC [NVEC] = '{
      {8'd2, 8'd8,  8'd0, 8'd8,  8'd0,  2'd0},
      {8'd1, 8'd8,  8'd0, 8'd0,  8'd0,  2'd0},
      {8'd2, 8'd16, 8'd8, 8'd8,  8'd16, 2'd0},
      {8'd3, 8'd24, 8'd0, 8'd0,  8'd24, 2'd0},
      {8'd2, 8'd16, 8'd0, 8'd8,  8'd0,  2'd1},
      {8'd5, 8'd8,  8'd0, 8'd8,  8'd0,  2'd2},
      {8'd1, 8'd8,  8'd8, 8'd0,  8'd0,  2'd1},
      {8'd2, 8'd8,  8'd0, 8'd0,  8'd8,  2'd0},
      {8'd1, 8'd0,  8'd8, 8'd0,  8'd0,  2'd0},
      {8'd3, 8'd8,  8'd8, 8'd16, 8'd0,  2'd0},
      {8'd2, 8'd12, 8'd4, 8'd16, 8'd0,  2'd1},
      {8'd0, 8'd8,  8'd0, 8'd8,  8'd0,  2'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        irq, overrun, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [1024];
   int          nchk = 0;
   int          nfail = 0;
   int          proto_viol = 0;
   logic        pend_q = 1'b0;
   logic [31:0] pend_addr = '0;
   logic [63:0] mkey = '0;

   always #10 clk = ~clk;

   dma_cb_engine i_dma_cb_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .irq       (irq),
      .overrun   (overrun),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   // Memory model: acknowledges one cycle after a request is seen
   always @(posedge clk) begin
      if (pend_q && (!mem_req || mem_addr != pend_addr)) proto_viol++;
      pend_q    <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
         else        mem_rdata <= mem[mem_addr[11:2]];
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] xf(input logic [7:0] op, input logic [63:0] x, input logic [63:0] k);
      return (op == 8'd3) ? ((x - k) ^ k) : ((x ^ k) + k);
   endfunction

   function automatic int saddr(input int w, input int l0, input int b0, input int b1);
      if (w * 4 < l0) return b0 + w * 4;
      return b1 + w * 4 - l0;
   endfunction

   function automatic logic [31:0] dword(input int v, input int w);
      return 32'hC0DE_0000 ^ (32'(v) << 8) ^ 32'(w);
   endfunction

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_sel   = sel;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic wait_irq(input string tag);
      int n = 0;
      while (!irq && n < 4000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, 64'(irq), 64'd1);
   endtask

   task automatic setup(input int cb, input logic [31:0] op, input logic [31:0] icnt,
                        input logic [31:0] ocnt, input int il0, input int il1,
                        input int ol0, input int ol1, input int v);
      mem[cb/4]     = op;
      mem[cb/4 + 1] = 32'hFFFF_FFFF;
      mem[cb/4 + 2] = 32'(IN_L);
      mem[cb/4 + 3] = icnt;
      mem[cb/4 + 4] = 32'(OUT_L);
      mem[cb/4 + 5] = ocnt;
      mem[IN_L/4]      = 32'(IN0);
      mem[IN_L/4 + 1]  = 32'(il0);
      mem[IN_L/4 + 2]  = 32'(IN1);
      mem[IN_L/4 + 3]  = 32'(il1);
      mem[OUT_L/4]     = 32'(OUT0);
      mem[OUT_L/4 + 1] = 32'(ol0);
      mem[OUT_L/4 + 2] = 32'(OUT1);
      mem[OUT_L/4 + 3] = 32'(ol1);
      for (int w = 0; w < (il0 + il1) / 4; w++) mem[saddr(w, il0, IN0, IN1) / 4] = dword(v, w);
      for (int w = 0; w < (ol0 + ol1) / 4; w++) mem[saddr(w, ol0, OUT0, OUT1) / 4] = 32'hBAD0_0000 | 32'(w);
   endtask

   task automatic clear_irq(input string tag);
      reg_write(1'b1, 32'd1);
      @(negedge clk);
      chk(tag, 64'(irq), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog (R1-related run hung): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 irq after reset", 64'(irq), 64'd0);
      chk("R12 overrun after reset", 64'(overrun), 64'd0);
      chk("R12 mem_req after reset", 64'(mem_req), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 mem_req idle", 64'(mem_req), 64'd0);

      // Vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] op;
         int il0, il1, ol0, ol1, tin, tout;
         logic [1:0] es;
         logic [63:0] xin, got;
         op  = VEC[v][41:34];
         il0 = int'(VEC[v][33:26]);
         il1 = int'(VEC[v][25:18]);
         ol0 = int'(VEC[v][17:10]);
         ol1 = int'(VEC[v][9:2]);
         es  = VEC[v][1:0];
         tin  = il0 + il1;
         tout = ol0 + ol1;
         setup(CB, 32'(op), 32'd2, 32'd2, il0, il1, ol0, ol1, v);
         reg_write(1'b0, 32'(CB));
         wait_irq("R9 irq after job");
         // R3 R4 R7 R9: status code
         chk($sformatf("R9 status vec %0d", v), 64'(mem[CB/4 + 1]), 64'(es));
         chk($sformatf("R1 opcode word intact vec %0d", v), 64'(mem[CB/4]), 64'(op));
         if ((op == 8'd2 || op == 8'd3) && es == 2'd0) begin
            for (int j = 0; j < tin / 8; j++) begin
               xin = {dword(v, 2*j + 1), dword(v, 2*j)};
               got = {mem[saddr(2*j + 1, ol0, OUT0, OUT1) / 4], mem[saddr(2*j, ol0, OUT0, OUT1) / 4]};
               chk($sformatf("R5 R6 block %0d vec %0d", j, v), got, xf(op, xin, mkey));
            end
         end else begin
            for (int w = 0; w < tout / 4; w++)
               chk($sformatf("R7 R3 output untouched w%0d vec %0d", w, v),
                   64'(mem[saddr(w, ol0, OUT0, OUT1) / 4]), 64'(32'hBAD0_0000 | 32'(w)));
         end
         if (op == 8'd1 && es == 2'd0) mkey = {dword(v, 1), dword(v, 0)};  // R4
         clear_irq("R10 irq cleared");
      end

      // R7: two empty lists succeed
      setup(CB, 32'd2, 32'd0, 32'd0, 0, 0, 0, 0, 20);
      reg_write(1'b0, 32'(CB));
      wait_irq("R9 irq empty job");
      chk("R7 empty lists status", 64'(mem[CB/4 + 1]), 64'd0);
      clear_irq("R10 clear");

      // R8: too many input entries
      setup(CB, 32'd2, 32'd17, 32'd2, 8, 0, 8, 0, 21);
      reg_write(1'b0, 32'(CB));
      wait_irq("R9 irq count job");
      chk("R8 count over limit status", 64'(mem[CB/4 + 1]), 64'd3);
      chk("R8 no output written", 64'(mem[OUT0/4]), 64'(32'hBAD0_0000));
      clear_irq("R10 clear");

      // R8: key load ignores the output count
      setup(CB, 32'd1, 32'd1, 32'd17, 8, 0, 0, 0, 22);
      reg_write(1'b0, 32'(CB));
      wait_irq("R9 irq key job");
      chk("R8 key load ignores out count", 64'(mem[CB/4 + 1]), 64'd0);
      mkey = {dword(22, 1), dword(22, 0)};
      clear_irq("R10 clear");

      // R1: alternate base, check key via encrypt at new base
      setup(CB_ALT, 32'd2, 32'd2, 32'd2, 8, 0, 8, 0, 23);
      reg_write(1'b0, 32'(CB_ALT));
      wait_irq("R9 irq alt base");
      chk("R1 status at alternate base", 64'(mem[CB_ALT/4 + 1]), 64'd0);
      chk("R4 key from second load", {mem[OUT0/4 + 1], mem[OUT0/4]},
          xf(8'd2, {dword(23, 1), dword(23, 0)}, mkey));
      // R10: irq holds without clear and ignores a zero clear
      repeat (30) @(negedge clk);
      chk("R10 irq holds", 64'(irq), 64'd1);
      reg_write(1'b1, 32'd0);
      @(negedge clk);
      chk("R10 zero clear ignored", 64'(irq), 64'd1);
      clear_irq("R10 clear");

      // R11: start while busy
      setup(CB, 32'd3, 32'd2, 32'd2, 16, 0, 0, 16, 24);
      mem[CB2/4 + 1] = 32'h1234_5678;
      reg_write(1'b0, 32'(CB));
      repeat (3) @(negedge clk);
      reg_write(1'b0, 32'(CB2));
      chk("R11 overrun set", 64'(overrun), 64'd1);
      wait_irq("R9 irq overrun job");
      chk("R11 first job done", 64'(mem[CB/4 + 1]), 64'd0);
      chk("R11 second start ignored", 64'(mem[CB2/4 + 1]), 64'h1234_5678);
      clear_irq("R10 clear");
      repeat (20) @(negedge clk);
      chk("R11 no second job", 64'(irq), 64'd0);
      chk("R11 overrun sticky", 64'(overrun), 64'd1);
      chk("R2 request held until acknowledge", 64'(proto_viol), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule